// File: doc/BRIEF.md
# Synchronous Burst Memory with Dual Address Strobes

This block is a clocked single-port memory of 2^ADDR_W words, each DATA_W bits wide. Every synchronous input is sampled on the rising clock edge. These inputs are the address, write data, write enable, the two chip selects and three burst strobes. A base address is loaded through one of two address strobes. After that, a 2-bit burst counter supplies the lowest address bits, so up to four accesses can follow one load. Each access after the first is either an advance to the next burst position or a repeat of the current one, which acts as a wait state. With the default parameters the array is small. Setting ADDR_W to 15 and DATA_W to 9 gives the full 32768 x 9 organisation.

A selection state machine has two states. ST_IDLE means deselected and ST_BURST means a burst is open. The transitions are as follows:
- "open" (ST_IDLE to ST_BURST): a strobe is low with the chip selected.
- "reload" (ST_BURST to ST_BURST): a strobe is low with the chip selected, which restarts the burst.
- "drop" (ST_BURST to ST_IDLE): a strobe is low with the chip not selected.
- "stay" (ST_IDLE to ST_IDLE): a strobe is low without selection.
- "hold" (either state to itself): both strobes are high.

The output enable is not registered. The data output is modelled as a value bus plus a drive-enable flag in place of a tri-state pin.

Top module: `burst_sram`

## Requirements
- R1: After reset the block is deselected and dout_en is 0 even with oe_n low.
- R2: If cpu_ads_n is low at an edge and the chip is selected (cs_hi=1, cs_lo_n=0), the burst restarts at addr with counter 0. A read is performed whatever we_n and ctl_ads_n are, and its data is on dout after that edge with dout_en=1.
- R3: If ctl_ads_n is low and cpu_ads_n is high at a selected edge, the burst restarts at addr. The first access is a write when we_n=0 and a read when we_n=1.
- R4: If either strobe is low at an edge where the chip is not selected, the block becomes deselected. It then drives nothing and performs no write on any following edge until a selected load.
- R5: The selects are ignored at edges where both strobes are high, and the current selection state carries on.
- R6: At an edge where both strobes are high and adv_n=0, the counter steps by one before the access. The accessed low two bits equal the loaded base low bits XOR the counter, which runs 0,1,2,3.
- R7: At an edge where both strobes are high and adv_n=1, the same address as the previous access is accessed again (wait state).
- R8: The upper address bits stay at the loaded base. After the fourth position, the next advance returns to the base address.
- R9: At continue and wait edges, we_n=0 selects a write and we_n=1 selects a read.
- R10: dout_en is 1 only after a selected read edge and only while oe_n is low. oe_n acts without a clock. A write edge leaves dout_en at 0.
- R11: Write data captured at an edge is stored at that edge and is returned by any later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| cpu_ads_n | input | 1 | Processor address strobe, active low, forces a read load |
| ctl_ads_n | input | 1 | Controller address strobe, active low, read or write load |
| adv_n | input | 1 | Burst advance, active low; high inserts a wait state |
| we_n | input | 1 | Write enable, active low |
| cs_hi | input | 1 | Active-high chip select, sampled on loads only |
| cs_lo_n | input | 1 | Active-low chip select, sampled on loads only |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | External base address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data of the last read access |
| dout_en | output | 1 | Output drive enable (high = driving, low = high impedance) |

## Verification
The array is filled with address-derived data through controller-strobe write bursts, each started at a different base low value. It is then read back through processor-strobe bursts that start at other low values, with we_n low to show that it is ignored. An extra advance on each readback shows the interleaved order and the wrap back to the base. Advance-held cycles separate a wait state from a step. Write-then-suspend-read cycles separate write and read in a continued burst. Loads with the chip unselected, and continue cycles with the selects deasserted, separate the sampling of the selects at loads from their being ignored afterwards. Toggling oe_n between clock edges shows that it gates the output without a clock.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    // selection state of the burst engine
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } sel_state_e;

    // access performed at a clock edge
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import burst_sram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_ads_n,
    input  logic ctl_ads_n,
    input  logic we_n,
    input  logic cs_hi,
    input  logic cs_lo_n,
    output logic load,
    output logic cont,
    output op_e  op
);

    sel_state_e state_q, state_nx;
    logic       strobe;
    logic       sel_ok;

    assign strobe = !cpu_ads_n || !ctl_ads_n;
    assign sel_ok = cs_hi && !cs_lo_n;

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (strobe && sel_ok) state_nx = ST_BURST;   // open
                else                  state_nx = ST_IDLE;    // stay / hold
            end
            ST_BURST: begin
                if (strobe && !sel_ok) state_nx = ST_IDLE;   // drop
                else                   state_nx = ST_BURST;  // reload / hold
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // per-edge outputs
    always_comb begin
        load = 1'b0;
        cont = 1'b0;
        op   = OP_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (strobe && sel_ok) begin
                    load = 1'b1;
                    op   = (!cpu_ads_n || we_n) ? OP_READ : OP_WRITE;
                end
            end
            ST_BURST: begin
                if (strobe && sel_ok) begin
                    load = 1'b1;
                    op   = (!cpu_ads_n || we_n) ? OP_READ : OP_WRITE;
                end else if (!strobe) begin
                    cont = 1'b1;
                    op   = we_n ? OP_READ : OP_WRITE;
                end
            end
            default: op = OP_NONE;
        endcase
    end

    AST_DROP_ON_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !sel_ok) |=> (state_q == ST_IDLE));           // R4
    AST_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe) |=> $stable(state_q));                         // R5
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !strobe) |-> (op == OP_NONE));    // R4

endmodule

// File: rtl/burst_addr.sv
module burst_addr #(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              cont,
    input  logic              step,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] acc_addr
);

    localparam int HI_W = ADDR_W - CNT_W;

    logic [ADDR_W-1:0] base_q, base_nx;
    logic [CNT_W-1:0]  cnt_q, cnt_nx;

    always_comb begin
        base_nx = base_q;
        cnt_nx  = cnt_q;
        if (load) begin
            base_nx = ext_addr;
            cnt_nx  = '0;
        end else if (cont && step) begin
            cnt_nx  = cnt_q + CNT_W'(1);
        end
    end

    // interleaved order: low bits = base low XOR count
    assign acc_addr = {base_nx[ADDR_W-1 -: HI_W], base_nx[CNT_W-1:0] ^ cnt_nx};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            base_q <= base_nx;
            cnt_q  <= cnt_nx;
        end
    end

    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == '0));                                             // R2
    AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && step) |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));    // R6
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && !step) |=> $stable(cnt_q));                                 // R7
    AST_BASE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!load) |=> $stable(base_q));                                        // R8

endmodule

// File: rtl/sram_array.sv
module sram_array
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_vld
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (op == OP_WRITE) mem[addr] <= din;
        if (op == OP_READ)  rdata     <= mem[addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_vld <= 1'b0;
        else        rd_vld <= (op == OP_READ);
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE) |=> (mem[$past(addr)] == $past(din)));  // R11
    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE) |=> !rd_vld);                           // R10
    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_READ) |=> rd_vld);                             // R2

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_ads_n,
    input  logic              ctl_ads_n,
    input  logic              adv_n,
    input  logic              we_n,
    input  logic              cs_hi,
    input  logic              cs_lo_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    localparam int CNT_W = 2;

    logic              load;
    logic              cont;
    op_e               op;
    logic [ADDR_W-1:0] acc_addr;
    logic              rd_vld;

    burst_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_ads_n (cpu_ads_n),
        .ctl_ads_n (ctl_ads_n),
        .we_n      (we_n),
        .cs_hi     (cs_hi),
        .cs_lo_n   (cs_lo_n),
        .load      (load),
        .cont      (cont),
        .op        (op)
    );

    burst_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .cont     (cont),
        .step     (!adv_n),
        .ext_addr (addr),
        .acc_addr (acc_addr)
    );

    sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .addr   (acc_addr),
        .din    (din),
        .rdata  (dout),
        .rd_vld (rd_vld)
    );

    // asynchronous output gate
    assign dout_en = rd_vld && !oe_n;

    AST_LOAD_NOT_CONT: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && cont));                                        // R5
    AST_CPU_LOAD_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_ads_n && cs_hi && !cs_lo_n) |=> rd_vld);           // R2

endmodule

// File: tb/burst_sram_tb_top.sv
module burst_sram_tb_top;

    localparam int AW = 10;
    localparam int DW = 9;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          cpu_ads_n, ctl_ads_n, adv_n, we_n, cs_hi, cs_lo_n, oe_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dout_en;

    burst_sram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_ads_n(cpu_ads_n), .ctl_ads_n(ctl_ads_n),
        .adv_n(adv_n), .we_n(we_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;
    logic [DW-1:0] mdl [1 << AW];

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // apply inputs at a falling edge, pass one rising edge, return at the next falling edge
    task automatic drive(bit p, bit c, bit a, bit w, bit sh, bit sl,
                         logic [AW-1:0] ad, logic [DW-1:0] d);
        cpu_ads_n = p; ctl_ads_n = c; adv_n = a; we_n = w;
        cs_hi = sh; cs_lo_n = sl; addr = ad; din = d;
        @(negedge clk);
    endtask

    function automatic logic [DW-1:0] pat(int a);
        return DW'((a * 37 + 5) & 9'h1FF);
    endfunction

    function automatic logic [AW-1:0] pos(logic [AW-1:0] b, int k);
        return {b[AW-1:2], b[1:0] ^ 2'(k)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] b;
        rst_n = 1'b0; oe_n = 1'b0;
        cpu_ads_n = 1; ctl_ads_n = 1; adv_n = 1; we_n = 1;
        cs_hi = 1; cs_lo_n = 0; addr = '0; din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset dout_en", {8'b0, dout_en}, 9'd0);

        // R3 / R6 / R9: write bursts through the controller strobe
        for (int g = 0; g < 16; g++) begin
            b = AW'(g * 4 + (g % 4));
            drive(1, 0, 1, 0, 1, 0, b, pat(pos(b, 0)));
            mdl[pos(b, 0)] = pat(pos(b, 0));
            chk("R3 write load no drive", {8'b0, dout_en}, 9'd0);
            for (int k = 1; k < 4; k++) begin
                drive(1, 1, 0, 0, 1, 0, '0, pat(pos(b, k)));
                mdl[pos(b, k)] = pat(pos(b, k));
            end
        end

        // R2 / R6 / R8 / R11: processor-strobe read bursts, we_n and ctl strobe low (ignored)
        for (int g = 0; g < 16; g++) begin
            b = AW'(g * 4 + ((g + 1) % 4));
            drive(0, 0, 1, 0, 1, 0, b, '0);
            chk("R2 cpu load reads", {8'b0, dout_en}, 9'd1);
            chk("R2 cpu load data", dout, mdl[pos(b, 0)]);
            for (int k = 1; k < 4; k++) begin
                drive(1, 1, 0, 1, 1, 0, '0, '0);
                chk("R6 interleaved advance", dout, mdl[pos(b, k)]);
            end
            drive(1, 1, 0, 1, 1, 0, '0, '0);
            chk("R8 wrap to base", dout, mdl[b]);
        end

        // R7: wait states
        b = AW'(37);
        drive(1, 0, 1, 1, 1, 0, b, '0);
        chk("R3 ctl read load", dout, mdl[pos(b, 0)]);
        drive(1, 1, 1, 1, 1, 0, '0, '0);
        chk("R7 wait repeats", dout, mdl[pos(b, 0)]);
        drive(1, 1, 0, 1, 1, 0, '0, '0);
        chk("R6 step after wait", dout, mdl[pos(b, 1)]);
        drive(1, 1, 1, 1, 1, 0, '0, '0);
        chk("R7 wait repeats 2", dout, mdl[pos(b, 1)]);

        // R9: write in a continued burst, then suspend-read it back
        drive(1, 1, 0, 0, 1, 0, '0, 9'h1A5);
        mdl[pos(b, 2)] = 9'h1A5;
        chk("R9 continue write no drive", {8'b0, dout_en}, 9'd0);
        drive(1, 1, 1, 1, 1, 0, '0, '0);
        chk("R9 suspend read", dout, 9'h1A5);
        chk("R11 stored value", {8'b0, dout_en}, 9'd1);

        // R4: deselect through the processor strobe, then attempted writes
        drive(0, 1, 1, 1, 0, 0, AW'(8), '0);
        chk("R4 deselect no drive", {8'b0, dout_en}, 9'd0);
        drive(1, 1, 0, 0, 1, 0, '0, 9'h0AA);
        chk("R4 idle write no drive", {8'b0, dout_en}, 9'd0);
        drive(1, 1, 1, 0, 1, 0, '0, 9'h0BB);
        drive(1, 1, 1, 1, 1, 0, '0, '0);
        chk("R4 idle read no drive", {8'b0, dout_en}, 9'd0);
        drive(0, 1, 1, 1, 1, 0, b, '0);
        chk("R4 base unchanged", dout, mdl[pos(b, 0)]);
        for (int k = 1; k < 4; k++) begin
            drive(1, 1, 0, 1, 1, 0, '0, '0);
            chk("R4 burst unchanged", dout, mdl[pos(b, k)]);
        end
        drive(1, 0, 1, 1, 1, 1, AW'(8), '0);
        chk("R4 ctl deselect", {8'b0, dout_en}, 9'd0);

        // R5: selects ignored on continue edges
        b = AW'(22);
        drive(0, 1, 1, 1, 1, 0, b, '0);
        drive(1, 1, 0, 1, 0, 1, '0, '0);
        chk("R5 still selected", {8'b0, dout_en}, 9'd1);
        chk("R5 continue data", dout, mdl[pos(b, 1)]);

        // R10: asynchronous output enable
        #1 oe_n = 1'b1;
        #1 chk("R10 oe high no drive", {8'b0, dout_en}, 9'd0);
        oe_n = 1'b0;
        #1 chk("R10 oe low drives", {8'b0, dout_en}, 9'd1);
        chk("R10 data held", dout, mdl[pos(b, 1)]);
        @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule